// File: doc/BRIEF.md
# Block-Copy DMA Engine

This engine copies a block of bytes from one place in a 16-bit byte address space to another. Software sets it up through five byte registers: a source address, a destination address and a control byte. Each address is split into a high and a low byte. Both addresses are forced to 16-byte alignment. The control byte holds a mode flag and a chunk count. A control write with the mode flag clear starts the copy at once. The copy runs in 16-byte chunks, and `busy` stays high for the whole copy so that the processor is held off.

The engine drives memory through a single request channel that uses valid/ready. For each byte it first issues a read of the source, waits for the read data on a response strobe, and then issues a write to the destination. When a chunk ends, a fixed overhead delay runs before the next chunk starts. This delay is 8 cycles, or 16 cycles when the double-speed input is high. A control write with the mode flag set is only recorded and reported back. It copies nothing.

Back-pressure rules on the request channel:
- The engine holds `mem_req_valid`, `mem_req_write`, `mem_req_addr` and `mem_req_wdata` stable until a cycle in which `mem_req_ready` is high.
- A request is accepted in any cycle where valid and ready are both high.
- For each accepted read, memory returns exactly one `mem_rsp_valid` pulse together with its data, at least one cycle later.
- Writes have no response.

Top module: `dma_block_copy`

## Requirements
- R1: Register select codes on `reg_addr`: 0 = source high, 1 = source low, 2 = destination high, 3 = destination low, 4 = control. A high write sets address bits 15:8. A low write sets bits 7:0 to the written byte with its low four bits forced to zero.
- R2: A control write of value n with bit 7 clear raises `busy` in the next cycle. `busy` stays high until (n[6:0]+1)×16 bytes have been copied and the last overhead delay has ended.
- R3: Each byte is a read of the current source address followed by a write of that data to the current destination address. Both addresses then increment by one and wrap modulo 2^16.
- R4: After every 16th byte, the engine waits 8 cycles before the next chunk (16 cycles when `speed_x2` is high). With a memory that is always ready and returns read data in the cycle after the request, a chunk therefore takes 56 busy cycles, or 64 with `speed_x2` high.
- R5: While `mem_req_valid` is high and `mem_req_ready` is low, the request (valid, address, direction, data) holds unchanged. Stalls lengthen the copy but do not change the bytes copied.
- R6: Reading select 4 returns bit 7 = completion flag and bits 6:0 = (remaining chunks − 1) mod 128. A control write with bit 7 clear sets the completion flag. After the copy has finished, the read returns 0xFF.
- R7: A control write with bit 7 set clears the completion flag, records the chunk count (a read returns 0x00 | n[6:0]), keeps `busy` low and issues no memory request.
- R8: Register writes made while `busy` is high have no effect.
- R9: The source and destination registers keep their incremented values after a copy. A later control write without new address writes continues from the end of the previous block.
- R10: After reset, `busy` is low and the control register reads 0xFF. Every select other than 4 reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for the current select (combinational) |
| speed_x2 | input | 1 | Double-speed flag; doubles the per-chunk overhead |
| busy | output | 1 | Copy in progress; the processor must wait |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_write | output | 1 | 1 = write request, 0 = read request |
| mem_req_addr | output | 16 | Request byte address |
| mem_req_wdata | output | 8 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 8 | Read data |

## Verification
The bound checker watches several rules on every cycle:
- a stalled request holds steady;
- there are no memory requests while the engine is idle;
- every copy begins with an aligned source read;
- the start, mode-set and ignored-write effects on the completion flag and `busy` behave as required.

Other behaviour only the bench scenarios can show, with a behavioural memory that returns a known pattern. This covers the exact byte order and addresses, including wrap at 0xFFFF, the total busy cycles per chunk at both speeds, the final 0xFF readback, and the continuation of addresses from one copy into the next.

// File: rtl/dma_bc_pkg.sv
package dma_bc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_WAIT,
    ST_WR,
    ST_OVH
  } xfer_state_t;

  localparam logic [2:0] SEL_SRC_HI = 3'd0;
  localparam logic [2:0] SEL_SRC_LO = 3'd1;
  localparam logic [2:0] SEL_DST_HI = 3'd2;
  localparam logic [2:0] SEL_DST_LO = 3'd3;
  localparam logic [2:0] SEL_CTRL   = 3'd4;
endpackage

// File: rtl/dma_bc_ovh_timer.sv
// Counts the fixed per-chunk overhead; done is high in the last overhead cycle.
module dma_bc_ovh_timer #(
  parameter int OVH_BASE = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic dbl,
  output logic done
);
  localparam int MAX_CYC = 2 * OVH_BASE;
  localparam int CW      = (MAX_CYC > 2) ? $clog2(MAX_CYC) : 1;

  logic [CW-1:0] cnt_q;
  logic          active_q;

  assign done = active_q && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (start) begin
      cnt_q    <= dbl ? CW'(MAX_CYC - 1) : CW'(OVH_BASE - 1);
      active_q <= 1'b1;
    end else if (done) begin
      active_q <= 1'b0;
    end else if (active_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/dma_bc_xfer.sv
// Per-byte read/write sequencer with chunk boundaries.
module dma_bc_xfer
  import dma_bc_pkg::*;
#(
  parameter int CHUNK_LOG2 = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic       last_chunk,
  input  logic       req_ready,
  input  logic       rsp_valid,
  input  logic [7:0] rsp_rdata,
  input  logic       ovh_done,
  output logic       req_valid,
  output logic       req_write,
  output logic [7:0] req_wdata,
  output logic       byte_step,
  output logic       chunk_step,
  output logic       ovh_start,
  output logic       busy
);
  xfer_state_t           st_q;
  logic [CHUNK_LOG2-1:0] idx_q;
  logic [7:0]            data_q;

  assign req_valid  = (st_q == ST_RD) || (st_q == ST_WR);
  assign req_write  = (st_q == ST_WR);
  assign req_wdata  = data_q;
  assign byte_step  = (st_q == ST_WR) && req_ready;
  assign ovh_start  = byte_step && (idx_q == '1);
  assign chunk_step = (st_q == ST_OVH) && ovh_done;
  assign busy       = (st_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      data_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          idx_q <= '0;
          if (go) st_q <= ST_RD;
        end
        ST_RD:   if (req_ready) st_q <= ST_WAIT;
        ST_WAIT: begin
          if (rsp_valid) begin
            data_q <= rsp_rdata;
            st_q   <= ST_WR;
          end
        end
        ST_WR: begin
          if (req_ready) begin
            idx_q <= idx_q + 1'b1;
            st_q  <= (idx_q == '1) ? ST_OVH : ST_RD;
          end
        end
        ST_OVH:  if (ovh_done) st_q <= last_chunk ? ST_IDLE : ST_RD;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_block_copy.sv
module dma_block_copy
  import dma_bc_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int LEN_W      = 7,
  parameter int CHUNK_LOG2 = 4,
  parameter int OVH_BASE   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              speed_x2,
  output logic              busy,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [7:0]        mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [7:0]        mem_rsp_rdata
);
  localparam int CNT_W = LEN_W + 1;

  logic [ADDR_W-1:0] src_q, dst_q;
  logic [CNT_W-1:0]  rem_q;
  logic              done_q;
  logic              byte_step, chunk_step, ovh_start, ovh_done;
  logic              reg_open, go;
  logic [CNT_W-1:0]  rem_m1;

  assign reg_open = reg_we && !busy;
  assign go       = reg_open && (reg_addr == SEL_CTRL) && !reg_wdata[7];
  assign rem_m1   = rem_q - 1'b1;

  always_comb begin
    if (reg_addr == SEL_CTRL) reg_rdata = {done_q, rem_m1[LEN_W-1:0]};
    else                      reg_rdata = '1;
  end

  assign mem_req_addr = mem_req_write ? dst_q : src_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q  <= '0;
      dst_q  <= '0;
      rem_q  <= '0;
      done_q <= 1'b1;
    end else if (reg_open) begin
      case (reg_addr)
        SEL_SRC_HI: src_q[ADDR_W-1:8] <= reg_wdata[ADDR_W-9:0];
        SEL_SRC_LO: src_q[7:0] <= {reg_wdata[7:CHUNK_LOG2], {CHUNK_LOG2{1'b0}}};
        SEL_DST_HI: dst_q[ADDR_W-1:8] <= reg_wdata[ADDR_W-9:0];
        SEL_DST_LO: dst_q[7:0] <= {reg_wdata[7:CHUNK_LOG2], {CHUNK_LOG2{1'b0}}};
        SEL_CTRL: begin
          rem_q  <= {1'b0, reg_wdata[LEN_W-1:0]} + 1'b1;
          done_q <= ~reg_wdata[7];
        end
        default: ;
      endcase
    end else begin
      if (byte_step) begin
        src_q <= src_q + 1'b1;
        dst_q <= dst_q + 1'b1;
      end
      if (chunk_step) rem_q <= rem_q - 1'b1;
    end
  end

  dma_bc_xfer #(.CHUNK_LOG2(CHUNK_LOG2)) u_xfer (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (go),
    .last_chunk (rem_q == CNT_W'(1)),
    .req_ready  (mem_req_ready),
    .rsp_valid  (mem_rsp_valid),
    .rsp_rdata  (mem_rsp_rdata),
    .ovh_done   (ovh_done),
    .req_valid  (mem_req_valid),
    .req_write  (mem_req_write),
    .req_wdata  (mem_req_wdata),
    .byte_step  (byte_step),
    .chunk_step (chunk_step),
    .ovh_start  (ovh_start),
    .busy       (busy)
  );

  dma_bc_ovh_timer #(.OVH_BASE(OVH_BASE)) u_ovh (
    .clk   (clk),
    .rst_n (rst_n),
    .start (ovh_start),
    .dbl   (speed_x2),
    .done  (ovh_done)
  );
endmodule

// File: rtl/dma_block_copy_chk.sv
module dma_block_copy_chk #(
  parameter int ADDR_W     = 16,
  parameter int CHUNK_LOG2 = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [2:0]        reg_addr,
  input logic [7:0]        reg_wdata,
  input logic              busy,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_write,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              done_q
);
  logic ctrl_wr;
  assign ctrl_wr = reg_we && !busy && (reg_addr == 3'd4);

  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=>
      mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write));

  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && !reg_wdata[7] |=> busy && done_q);

  p_mode_set_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && reg_wdata[7] |=> !busy && !done_q);

  p_idle_no_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req_valid);

  p_aligned_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> mem_req_valid && !mem_req_write &&
                    (mem_req_addr[CHUNK_LOG2-1:0] == '0));

  p_busy_write_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && reg_we |=> $stable(done_q));
endmodule

bind dma_block_copy dma_block_copy_chk #(.ADDR_W(ADDR_W), .CHUNK_LOG2(CHUNK_LOG2)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .reg_we        (reg_we),
  .reg_addr      (reg_addr),
  .reg_wdata     (reg_wdata),
  .busy          (busy),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_write (mem_req_write),
  .mem_req_addr  (mem_req_addr),
  .done_q        (done_q)
);

// File: tb/test_dma_block_copy.sv
module test_dma_block_copy;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [7:0]  reg_wdata = 8'd0;
  logic [7:0]  reg_rdata;
  logic        speed_x2 = 1'b0;
  logic        busy;
  logic        mem_req_valid, mem_req_write;
  logic        mem_req_ready = 1'b1;
  logic [15:0] mem_req_addr;
  logic [7:0]  mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [7:0]  mem_rsp_rdata = 8'd0;

  int n_tests = 0, n_fail = 0;
  logic        stall_en = 1'b0;
  logic [15:0] exp_src = 16'd0, exp_dst = 16'd0;
  int rd_n = 0, wr_n = 0, mon_err = 0, busy_cyc = 0;

  always #10 clk = ~clk;

  dma_block_copy i_dma_block_copy (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .speed_x2(speed_x2),
    .busy(busy), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata)
  );

  function automatic logic [7:0] pat(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction

  // behavioural memory: pattern source, one-cycle read latency, optional stalls
  always @(posedge clk) begin
    mem_rsp_valid <= mem_req_valid && mem_req_ready && !mem_req_write;
    mem_rsp_rdata <= pat(mem_req_addr);
    mem_req_ready <= stall_en ? ~mem_req_ready : 1'b1;
  end

  // monitor of byte order and data
  always @(posedge clk) begin
    if (rst_n) begin
      if (busy) busy_cyc++;
      if (mem_req_valid && mem_req_ready) begin
        if (!mem_req_write) begin
          if (mem_req_addr != exp_src + 16'(rd_n)) mon_err++;
          rd_n++;
        end else begin
          if (mem_req_addr != exp_dst + 16'(wr_n)) mon_err++;
          if (mem_req_wdata != pat(exp_src + 16'(wr_n))) mon_err++;
          wr_n++;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic clear_mon(input logic [15:0] s, input logic [15:0] d);
    exp_src = s; exp_dst = d; rd_n = 0; wr_n = 0; mon_err = 0; busy_cyc = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic set_addrs(input logic [15:0] s, input logic [15:0] d);
    reg_wr(3'd0, s[15:8]); reg_wr(3'd1, s[7:0]);
    reg_wr(3'd2, d[15:8]); reg_wr(3'd3, d[7:0]);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check(busy == 1'b0, "R10 busy after reset", busy, 0);
    reg_rd(3'd4, v); check(v == 8'hFF, "R10 ctrl after reset", v, 8'hFF);
    reg_rd(3'd2, v); check(v == 8'hFF, "R10 other select", v, 8'hFF);
    reg_rd(3'd7, v); check(v == 8'hFF, "R10 unused select", v, 8'hFF);
  endtask

  // one copy with zero-wait memory; checks order, count, cycles, readback
  task automatic t_copy(input logic [15:0] s_wr, input logic [15:0] d_wr,
                        input int n, input bit ds, input string tag);
    logic [7:0] v;
    int bytes, exp_cyc;
    bytes = (n + 1) * 16;
    exp_cyc = (n + 1) * (48 + (8 << ds));
    speed_x2 = ds;
    set_addrs(s_wr, d_wr);
    clear_mon({s_wr[15:4], 4'h0}, {d_wr[15:4], 4'h0});
    reg_wr(3'd4, 8'(n));
    check(busy == 1'b1, {tag, " R2 busy after start"}, busy, 1);
    wait_idle();
    check(wr_n == bytes, {tag, " R2 byte count"}, wr_n, bytes);
    check(rd_n == bytes, {tag, " R3 read count"}, rd_n, bytes);
    check(mon_err == 0, {tag, " R1 R3 address/data order"}, mon_err, 0);
    check(busy_cyc == exp_cyc, {tag, " R4 busy cycles"}, busy_cyc, exp_cyc);
    reg_rd(3'd4, v); check(v == 8'hFF, {tag, " R6 final readback"}, v, 8'hFF);
  endtask

  task automatic t_stall();
    int nostall;
    nostall = 2 * 56;
    stall_en = 1'b1; speed_x2 = 1'b0;
    set_addrs(16'h2340, 16'h8000);
    clear_mon(16'h2340, 16'h8000);
    reg_wr(3'd4, 8'h01);
    wait_idle();
    stall_en = 1'b0;
    check(wr_n == 32 && mon_err == 0, "R5 stalled copy data", mon_err, 0);
    check(busy_cyc > nostall, "R5 stalls lengthen copy", busy_cyc, nostall);
  endtask

  task automatic t_mode_set();
    logic [7:0] v;
    set_addrs(16'h1000, 16'h2000);
    clear_mon(16'h1000, 16'h2000);
    reg_wr(3'd4, 8'h85);
    reg_rd(3'd4, v); check(v == 8'h05, "R7 mode-set readback", v, 8'h05);
    repeat (20) @(negedge clk);
    check(rd_n + wr_n == 0, "R7 no memory traffic", rd_n + wr_n, 0);
    check(busy_cyc == 0, "R7 busy stays low", busy_cyc, 0);
  endtask

  task automatic t_ignore_continue();
    logic [7:0] v;
    speed_x2 = 1'b0;
    set_addrs(16'h4A00, 16'h6B10);
    clear_mon(16'h4A00, 16'h6B10);
    reg_wr(3'd4, 8'h01);
    repeat (5) @(negedge clk);
    reg_wr(3'd0, 8'hAA);   // ignored: source high while busy
    reg_wr(3'd4, 8'h83);   // ignored: control while busy
    wait_idle();
    check(wr_n == 32 && mon_err == 0, "R8 copy unaffected by busy writes", mon_err, 0);
    reg_rd(3'd4, v); check(v == 8'hFF, "R8 control unchanged", v, 8'hFF);
    clear_mon(16'h4A20, 16'h6B30);
    reg_wr(3'd4, 8'h00);
    wait_idle();
    check(wr_n == 16 && mon_err == 0, "R9 continues after previous block", mon_err, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_copy(16'hC000, 16'h8000, 0, 1'b0, "basic");
    t_copy(16'h1237, 16'h9A5F, 3, 1'b1, "x2 unaligned");
    t_copy(16'hFFF0, 16'hFFE0, 1, 1'b0, "wrap");
    t_stall();
    t_mode_set();
    t_ignore_continue();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule